// File: doc/BRIEF.md
# Power-Up Stable Word Selector

This block picks SRAM words whose power-up contents repeat, so that they can serve as key material. After a start pulse it asks for a power cycle of the source array. It then reads every word once and keeps that snapshot in an internal reference RAM. Once this copy is complete, every word carries a set "still valid" flag.

The block then runs a fixed number of assessment rounds. Each round requests another power cycle and reads only the words that are still valid. A word whose new value differs from its reference value loses its flag, and it never gets the flag back.

When the last round has finished, the flags are scanned from address zero upward. The first words still valid give enough addresses for a 128-bit key (eight 16-bit words). The address list is presented for storage in non-volatile memory. If too few words survive, a failure flag is raised instead. The power cycling itself is done outside the block, through a request/acknowledge handshake.

Top module: `stable_word_finder`

## Requirements
- R1: After synchronous reset, `pwr_req`, `src_en`, `done`, `fail` and `key_valid` are 0 and `key_addrs` is all zeros.
- R2: One start gives exactly ROUNDS+1 power-cycle requests, one at a time. Each `pwr_req` stays high until the cycle in which `pwr_ack` is seen.
- R3: The pass after the first power cycle reads every address exactly once and stores those values as the reference.
- R4: A word is invalid if its value after any later power cycle differs from its reference value. An invalid word stays invalid for the rest of the run.
- R5: Each assessment pass reads only words still valid at its start, so its read count equals the number of valid words.
- R6: On success, `key_valid`=1, `fail`=0, and slot i of `key_addrs` (bits i*AW and up, AW address bits) holds the i-th lowest valid address.
- R7: If fewer than KEY_BITS/WORD_W words remain valid, `fail`=1, `key_valid`=0 and `key_addrs` is all zeros.
- R8: `done` and the result stay unchanged until the next start. A start received while a run is in progress has no effect.
- R9: No source read is issued while `pwr_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a selection run (accepted when idle or done) |
| pwr_req | output | 1 | Power-cycle request to the source array |
| pwr_ack | input | 1 | One-cycle acknowledge: fresh power-up contents are ready |
| src_en | output | 1 | Source read enable; data is returned on the next clock edge |
| src_addr | output | AW | Source read address |
| src_data | input | WORD_W | Source read data |
| done | output | 1 | Run finished; result is valid |
| fail | output | 1 | Too few stable words |
| key_valid | output | 1 | Address list is valid |
| key_addrs | output | KEY_WORDS*AW | Selected addresses, slot 0 in the low bits |

## Verification
In the same cycle, the compare stage may clear the flag of one word while the issue stage reads the flag of the next word to decide whether to read it. Runs in which neighbouring words flip in alternate power-ups provoke this overlap. In these runs the bench counts the reads in every pass against its own model of the surviving words, and then compares the final address list slot by slot against the addresses it computed.

// File: rtl/stable_word_pkg.sv
package stable_word_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PWR, ST_SCAN, ST_DRAIN, ST_SEL, ST_FIN, ST_DONE
  } sel_state_e;
endpackage

// File: rtl/ref_ram.sv
module ref_ram #(
  parameter int DEPTH  = 256,
  parameter int WORD_W = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/addr_collector.sv
module addr_collector #(
  parameter int AW    = 8,
  parameter int SLOTS = 8,
  localparam int CW   = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              take,
  input  logic [AW-1:0]     addr,
  output logic              full,
  output logic [SLOTS*AW-1:0] slots
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (take && cnt != CW'(SLOTS)) cnt <= cnt + 1'b1;
  end

  assign full = (cnt == CW'(SLOTS));

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clear) slots[i*AW +: AW] <= '0;
      else if (take && cnt == CW'(i)) slots[i*AW +: AW] <= addr;
    end
  end

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(SLOTS));
  assert_full_stays_R6: assert property (@(posedge clk) disable iff (rst)
    (full && !clear) |=> full);
endmodule

// File: rtl/stable_word_finder.sv
module stable_word_finder #(
  parameter int WORD_W   = 16,
  parameter int DEPTH    = 256,
  parameter int ROUNDS   = 149,
  parameter int KEY_BITS = 128,
  localparam int AW        = $clog2(DEPTH),
  localparam int KEY_WORDS = KEY_BITS / WORD_W,
  localparam int RW        = $clog2(ROUNDS + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  output logic                  pwr_req,
  input  logic                  pwr_ack,
  output logic                  src_en,
  output logic [AW-1:0]         src_addr,
  input  logic [WORD_W-1:0]     src_data,
  output logic                  done,
  output logic                  fail,
  output logic                  key_valid,
  output logic [KEY_WORDS*AW-1:0] key_addrs
);
  import stable_word_pkg::*;

  sel_state_e        st;
  logic              copy_pass;
  logic [RW-1:0]     rnd;
  logic [AW-1:0]     scan_a;
  logic [AW-1:0]     sel_a;
  logic [DEPTH-1:0]  vld;
  logic              cmp_v;
  logic [AW-1:0]     cmp_addr;
  logic [WORD_W-1:0] ref_q;
  logic              col_full;
  logic [KEY_WORDS*AW-1:0] col_slots;
  logic              col_take;
  logic              pipe_empty;
  logic              go;

  assign go         = start && (st == ST_IDLE || st == ST_DONE);
  assign pipe_empty = !src_en && !cmp_v;
  assign col_take   = (st == ST_SEL) && vld[sel_a] && !col_full;

  ref_ram #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_ref (
    .clk   (clk),
    .we    (cmp_v && copy_pass),
    .waddr (cmp_addr),
    .wdata (src_data),
    .re    (src_en),
    .raddr (src_addr),
    .rdata (ref_q)
  );

  addr_collector #(.AW(AW), .SLOTS(KEY_WORDS)) u_col (
    .clk   (clk),
    .rst   (rst),
    .clear (go),
    .take  (col_take),
    .addr  (sel_a),
    .full  (col_full),
    .slots (col_slots)
  );

  // compare stage: data and reference arrive together one edge after issue
  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_v    <= 1'b0;
      cmp_addr <= '0;
    end else begin
      cmp_v    <= src_en;
      cmp_addr <= src_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
    end else if (st == ST_DRAIN && pipe_empty && copy_pass) begin
      vld <= '1;
    end else if (cmp_v && !copy_pass && src_data != ref_q) begin
      vld[cmp_addr] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      copy_pass <= 1'b0;
      rnd       <= '0;
      scan_a    <= '0;
      sel_a     <= '0;
      pwr_req   <= 1'b0;
      src_en    <= 1'b0;
      src_addr  <= '0;
      done      <= 1'b0;
      fail      <= 1'b0;
      key_valid <= 1'b0;
      key_addrs <= '0;
    end else begin
      src_en <= 1'b0;
      case (st)
        ST_IDLE, ST_DONE: begin
          if (go) begin
            st        <= ST_PWR;
            copy_pass <= 1'b1;
            rnd       <= '0;
            pwr_req   <= 1'b1;
            done      <= 1'b0;
            fail      <= 1'b0;
            key_valid <= 1'b0;
            key_addrs <= '0;
          end
        end
        ST_PWR: begin
          if (pwr_ack) begin
            pwr_req <= 1'b0;
            scan_a  <= '0;
            st      <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          src_en   <= copy_pass || vld[scan_a];
          src_addr <= scan_a;
          if (scan_a == AW'(DEPTH - 1)) st <= ST_DRAIN;
          else scan_a <= scan_a + 1'b1;
        end
        ST_DRAIN: begin
          if (pipe_empty) begin
            if (!copy_pass && rnd == RW'(ROUNDS - 1)) begin
              sel_a <= '0;
              st    <= ST_SEL;
            end else begin
              if (!copy_pass) rnd <= rnd + 1'b1;
              copy_pass <= 1'b0;
              pwr_req   <= 1'b1;
              st        <= ST_PWR;
            end
          end
        end
        ST_SEL: begin
          if (col_full || sel_a == AW'(DEPTH - 1)) st <= ST_FIN;
          else sel_a <= sel_a + 1'b1;
        end
        ST_FIN: begin
          done      <= 1'b1;
          key_valid <= col_full;
          fail      <= !col_full;
          key_addrs <= col_full ? col_slots : '0;
          st        <= ST_DONE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_req_held_R2: assert property (@(posedge clk) disable iff (rst)
    (pwr_req && !pwr_ack) |=> pwr_req);
  assert_no_read_in_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    pwr_req |-> !src_en);
  assert_flag_never_set_R4: assert property (@(posedge clk) disable iff (rst)
    (st != ST_DRAIN) |=> ((vld & ~$past(vld)) == '0));
  assert_flags_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SEL) |=> $stable(vld));
  assert_result_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(key_valid && fail));
  assert_done_held_R8: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(key_addrs)));
endmodule

// File: tb/tb_stable_word_finder.sv
module tb_stable_word_finder;
  localparam int WW = 16;
  localparam int D  = 32;
  localparam int RN = 4;
  localparam int KB = 128;
  localparam int KW = KB / WW;
  localparam int AW = $clog2(D);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic pwr_ack = 1'b0;
  logic pwr_req, src_en, done, fail, key_valid;
  logic [AW-1:0] src_addr;
  logic [WW-1:0] src_data;
  logic [KW*AW-1:0] key_addrs;

  stable_word_finder #(.WORD_W(WW), .DEPTH(D), .ROUNDS(RN), .KEY_BITS(KB)) dut (
    .clk(clk), .rst(rst), .start(start), .pwr_req(pwr_req), .pwr_ack(pwr_ack),
    .src_en(src_en), .src_addr(src_addr), .src_data(src_data), .done(done),
    .fail(fail), .key_valid(key_valid), .key_addrs(key_addrs)
  );

  always #5 clk = ~clk;

  logic [WW-1:0] mem [D];
  int rd_count = 0;
  always @(posedge clk) begin
    if (src_en) begin
      src_data <= mem[src_addr];
      rd_count <= rd_count + 1;
    end
  end

  int checks = 0;
  int errors = 0;
  bit stab [D];
  bit alt_flip;
  int late_flip;
  logic [WW-1:0] basev [D];
  logic [WW-1:0] refm  [D];
  bit expv [D];
  int pwr_n, rd_base, exp_reads;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int popc();
    int n = 0;
    for (int a = 0; a < D; a++) n += expv[a];
    return n;
  endfunction

  task automatic power_up();
    logic [WW-1:0] w;
    if (pwr_n > 0)
      chk(rd_count - rd_base == exp_reads, (pwr_n == 1) ? "R3" : "R5",
          "pass reads", rd_count - rd_base, exp_reads);
    exp_reads = (pwr_n == 0) ? D : popc();
    rd_base = rd_count;
    pwr_n++;
    for (int a = 0; a < D; a++) begin
      if (stab[a]) w = basev[a];
      else if (alt_flip) w = basev[a] ^ {15'd0, pwr_n[0]};
      else w = (($urandom % 2) == 0) ? basev[a] : basev[a] ^ (16'h1 << ($urandom % 16));
      if (a == late_flip && pwr_n == RN + 1) w = basev[a] ^ 16'h8000;
      mem[a] = w;
      if (pwr_n == 1) begin
        refm[a] = w;
        expv[a] = 1'b1;
      end else begin
        expv[a] = expv[a] && (w == refm[a]);
      end
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (pwr_req) begin
        repeat (3) @(negedge clk);
        chk(pwr_req == 1'b1, "R2", "request held", pwr_req, 1);
        power_up();
        pwr_ack = 1'b1;
        @(negedge clk);
        pwr_ack = 1'b0;
      end
    end
  end

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_case(string name, bit extra_start);
    int exp_a [KW];
    int n = 0;
    int waited = 0;
    logic [KW*AW-1:0] held;
    pwr_n = 0;
    pulse_start();
    if (extra_start) begin
      repeat (20) @(negedge clk);
      pulse_start(); // R8: start during a run must be ignored
    end
    while (!done && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    chk(done == 1'b1, "R8", {name, " done"}, done, 1);
    chk(rd_count - rd_base == exp_reads, "R5", {name, " last pass reads"},
        rd_count - rd_base, exp_reads);
    chk(pwr_n == RN + 1, "R2", {name, " power cycles"}, pwr_n, RN + 1);
    for (int a = 0; a < D; a++)
      if (expv[a] && n < KW) begin
        exp_a[n] = a;
        n++;
      end
    if (n >= KW) begin
      chk(fail == 1'b0 && key_valid == 1'b1, "R6", {name, " success flags"},
          {fail, key_valid}, 1);
      for (int i = 0; i < KW; i++)
        chk(int'(key_addrs[i*AW +: AW]) == exp_a[i], "R6", {name, " slot"},
            key_addrs[i*AW +: AW], exp_a[i]);
    end else begin
      chk(fail == 1'b1 && key_valid == 1'b0, "R7", {name, " failure flags"},
          {fail, key_valid}, 2);
      chk(key_addrs == '0, "R7", {name, " no addresses"}, key_addrs, 0);
    end
    held = key_addrs;
    repeat (6) @(negedge clk);
    chk(done == 1'b1 && key_addrs == held, "R8", {name, " result held"},
        key_addrs, held);
  endtask

  task automatic setup(int stable_pct);
    alt_flip = 1'b0;
    late_flip = -1;
    for (int a = 0; a < D; a++) begin
      basev[a] = WW'($urandom);
      stab[a] = (($urandom % 100) < stable_pct);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int a = 0; a < D; a++) mem[a] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(pwr_req == 0 && src_en == 0 && done == 0 && fail == 0 && key_valid == 0,
        "R1", "reset outputs", {pwr_req, src_en, done, fail, key_valid}, 0);
    chk(key_addrs == '0, "R1", "reset addresses", key_addrs, 0);

    setup(100);
    run_case("all stable", 1'b0);

    for (int k = 0; k < 3; k++) begin
      setup(45);
      run_case("random", 1'b0);
    end

    setup(0);
    for (int a = 3; a < D; a += 6) stab[a] = 1'b1;
    run_case("five stable R7", 1'b0);

    setup(0);
    alt_flip = 1'b1;
    for (int a = D - KW; a < D; a++) stab[a] = 1'b1;
    run_case("top block adjacent flips R4", 1'b0);

    setup(0);
    for (int a = 0; a < 2 * KW; a += 2) stab[a] = 1'b1;
    stab[1] = 1'b1;
    late_flip = 1;
    run_case("late flip R4", 1'b0);

    setup(60);
    run_case("start while busy R8", 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule